// File: doc/BRIEF.md
# Second-Operand Shifter with Rotated Immediate

This block forms the second ALU operand and the shifter carry-out for a data-processing instruction. The decode stage supplies the 12-bit operand field of the instruction, the immediate-select bit, the register value that is to be shifted, the register that may hold a shift count, and the current carry flag. The block returns the shaped 32-bit operand and the carry that a flag-setting logical operation writes back.

There are two paths. The immediate path widens an 8-bit constant and rotates it right by twice a 4-bit count. The register path applies a logical left shift, a logical right shift, an arithmetic right shift, a rotate right, or a one-bit rotate through the carry. The count comes either from a 5-bit field or from the low byte of the count register. Register fetch happens outside the block, so the register-index bits of the field are not used here. The block is purely combinational and sits between the register-read and execute stages.

Top module: `opsh_top`

## Requirements
- R1: With imm_sel=1, operand equals field[7:0] zero-extended and rotated right by 2×field[11:8]. c_out is c_in when field[11:8]=0, and operand[31] otherwise. rm_val and rs_val have no effect.
- R2: With imm_sel=0, field[6:5] selects the shift: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. field[4]=0 takes the count from field[11:7], and field[4]=1 takes it from rs_val[7:0]. field[3:0] has no effect.
- R3: A left logical shift fills with zeros, and c_out is the last bit shifted out. A count of 32 gives 0 with c_out=rm_val[0]. A count above 32 gives 0 with c_out=0.
- R4: A right logical shift fills with zeros, and c_out is the last bit shifted out. A field count of 0 means a count of 32, which gives 0 with c_out=rm_val[31]. A register count above 32 gives 0 with c_out=0.
- R5: A right arithmetic shift fills with copies of rm_val[31]. A field count of 0 means 32. A count of 32 or more gives 32 copies of rm_val[31] and sets c_out to rm_val[31].
- R6: A rotate right with a register count uses the count modulo 32. A nonzero count that is a multiple of 32 returns rm_val unchanged with c_out=rm_val[31]. Otherwise c_out=operand[31].
- R7: A rotate right with field count 0 rotates one place through the carry: operand={c_in, rm_val[31:1]} and c_out=rm_val[0].
- R8: A register count whose low byte is 0 passes rm_val through with c_out=c_in, for every shift type. rs_val[31:8] has no effect.
- R9: A left logical shift with field count 0 passes rm_val through with c_out=c_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| imm_sel | input | 1 | 1 selects the rotated-immediate path |
| op_field | input | 12 | Operand field of the instruction |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the count register |
| c_in | input | 1 | Current carry flag |
| operand | output | 32 | Shaped second operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
The bench builds the block at its default width of 32 with an 8-bit count and the staged rotator. At these values the count space is small enough to sweep in full. For every shift type and several data patterns, the sweep covers every 5-bit field count and every one of the 256 register counts, with garbage in the upper count-register bits. That exercises all the boundaries at 0, 31, 32, 33 and multiples of 32. Every rotation of several immediates with both carry values is checked as well. A bit-serial reference model in the bench produces the expected values.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   localparam int FIELD_W   = 12;
   localparam int IMM_W     = 8;
   localparam int ROT_W     = 4;
   localparam int SAMT_W    = 5;
   localparam int ROT_LSB   = 8;
   localparam int SAMT_LSB  = 7;
   localparam int KIND_LSB  = 5;
   localparam int REGCNT_B  = 4;

endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
   import opsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic                imm_sel,
   input  logic [FIELD_W-1:0]  field,
   input  logic [DATA_W-1:0]   rm_val,
   input  logic [DATA_W-1:0]   rs_val,
   output shift_kind_e         kind,
   output logic [CNT_W-1:0]    amt,
   output logic [DATA_W-1:0]   src
);

   logic [ROT_W-1:0]  rot_f;
   logic [SAMT_W-1:0] samt_f;
   logic [1:0]        kind_f;
   logic              unused_bits;

   assign rot_f       = field[ROT_LSB +: ROT_W];
   assign samt_f      = field[SAMT_LSB +: SAMT_W];
   assign kind_f      = field[KIND_LSB +: 2];
   assign unused_bits = ^{field[3:0], rs_val[DATA_W-1:CNT_W]};

   always_comb begin
      kind = SK_LSL;
      amt  = '0;
      src  = rm_val;
      if (imm_sel) begin
         kind = SK_ROR;
         src  = DATA_W'(field[IMM_W-1:0]);
         amt  = CNT_W'({rot_f, 1'b0});
      end else begin
         kind = shift_kind_e'({1'b0, kind_f});
         if (field[REGCNT_B]) begin
            amt = rs_val[CNT_W-1:0];
         end else if (samt_f == '0) begin
            case (kind_f)
               2'b00:   amt  = '0;
               2'b11:   kind = SK_RRX;
               default: amt  = CNT_W'(DATA_W);
            endcase
         end else begin
            amt = CNT_W'(samt_f);
         end
      end
   end

   // R1: the immediate path always asks for an even rotate of at most width-2
   always_comb begin
      if (imm_sel == 1'b1) begin
         p_imm_even_rot_r1: assert (kind == SK_ROR && !amt[0] && amt <= CNT_W'(DATA_W - 2))
            else $error("immediate path produced a bad rotate request");
      end
   end

   // R4: a field-sourced right shift never asks for more than one full width
   always_comb begin
      if (imm_sel == 1'b0 && field[REGCNT_B] == 1'b0 && kind == SK_LSR) begin
         p_field_cnt_cap_r4: assert (amt != '0 && amt <= CNT_W'(DATA_W))
            else $error("field count outside 1..width");
      end
   end

endmodule

// File: rtl/opsh_core.sv
module opsh_core
   import opsh_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 8,
   parameter bit STAGED_ROTATE = 1'b1
) (
   input  shift_kind_e         kind,
   input  logic [CNT_W-1:0]    amt,
   input  logic [DATA_W-1:0]   val,
   input  logic                c_in,
   output logic [DATA_W-1:0]   res,
   output logic                cout
);

   localparam int SH_W = $clog2(DATA_W);

   logic [DATA_W:0]   lsl_ext;
   logic [DATA_W:0]   lsr_ext;
   logic [DATA_W:0]   asr_ext;
   logic [SH_W-1:0]   rot_amt;
   logic [DATA_W-1:0] ror_res;

   // one guard bit beyond the data catches the last bit shifted out
   assign lsl_ext = {1'b0, val} << amt;
   assign lsr_ext = {val, 1'b0} >> amt;
   assign asr_ext = $signed({val, 1'b0}) >>> amt;
   assign rot_amt = amt[SH_W-1:0];

   generate
      if (STAGED_ROTATE) begin : g_staged
         logic [DATA_W-1:0] stage [SH_W+1];
         assign stage[0] = val;
         for (genvar s = 0; s < SH_W; s++) begin : g_st
            assign stage[s+1] = rot_amt[s]
               ? {stage[s][(1<<s)-1:0], stage[s][DATA_W-1:(1<<s)]}
               : stage[s];
         end
         assign ror_res = stage[SH_W];
      end else begin : g_operator
         assign ror_res = DATA_W'({val, val} >> rot_amt);
      end
   endgenerate

   always_comb begin
      res  = val;
      cout = c_in;
      if (amt != '0 || kind == SK_RRX) begin
         unique case (kind)
            SK_LSL: begin res = lsl_ext[DATA_W-1:0]; cout = lsl_ext[DATA_W]; end
            SK_LSR: begin res = lsr_ext[DATA_W:1];   cout = lsr_ext[0];      end
            SK_ASR: begin res = asr_ext[DATA_W:1];   cout = asr_ext[0];      end
            SK_ROR: begin res = ror_res;             cout = ror_res[DATA_W-1]; end
            SK_RRX: begin res = {c_in, val[DATA_W-1:1]}; cout = val[0];      end
            default: begin res = val; cout = c_in; end
         endcase
      end
   end

   // R3: left shift past the width leaves nothing, not even a carry
   always_comb begin
      if (kind == SK_LSL && amt > CNT_W'(DATA_W)) begin
         p_lsl_flush_r3: assert (res == '0 && cout == 1'b0)
            else $error("left shift past width not cleared");
      end
   end

   // R5: arithmetic shift of a full width or more saturates to the sign
   always_comb begin
      if (kind == SK_ASR && amt >= CNT_W'(DATA_W)) begin
         p_asr_sat_r5: assert (res == {DATA_W{val[DATA_W-1]}} && cout == val[DATA_W-1])
            else $error("arithmetic shift did not saturate");
      end
   end

   // R6: a rotation keeps the number of set bits and reports the new top bit
   always_comb begin
      if (kind == SK_ROR && amt != '0) begin
         p_ror_popcount_r6: assert ($countones(res) == $countones(val) && cout == res[DATA_W-1])
            else $error("rotate lost bits or carry");
      end
   end

   // R7: rotate through carry puts the old carry on top
   always_comb begin
      if (kind == SK_RRX) begin
         p_rrx_carry_r7: assert (res[DATA_W-1] == c_in && cout == val[0])
            else $error("rotate through carry wrong");
      end
   end

endmodule

// File: rtl/opsh_top.sv
module opsh_top
   import opsh_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 8,
   parameter bit STAGED_ROTATE = 1'b1
) (
   input  logic                imm_sel,
   input  logic [FIELD_W-1:0]  op_field,
   input  logic [DATA_W-1:0]   rm_val,
   input  logic [DATA_W-1:0]   rs_val,
   input  logic                c_in,
   output logic [DATA_W-1:0]   operand,
   output logic                c_out
);

   generate
      if ((1 << SAMT_W) != DATA_W) begin : g_bad_width
         $error("DATA_W must match the 5-bit shift field");
      end
      if ((2 << ROT_W) != DATA_W) begin : g_bad_rot
         $error("DATA_W must match twice the rotate field range");
      end
      if (CNT_W <= SAMT_W || CNT_W >= DATA_W) begin : g_bad_cnt
         $error("CNT_W must exceed the field count width and stay below DATA_W");
      end
   endgenerate

   shift_kind_e       kind;
   logic [CNT_W-1:0]  amt;
   logic [DATA_W-1:0] src;

   opsh_decode #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) i_decode (
      .imm_sel (imm_sel),
      .field   (op_field),
      .rm_val  (rm_val),
      .rs_val  (rs_val),
      .kind    (kind),
      .amt     (amt),
      .src     (src)
   );

   opsh_core #(
      .DATA_W        (DATA_W),
      .CNT_W         (CNT_W),
      .STAGED_ROTATE (STAGED_ROTATE)
   ) i_core (
      .kind (kind),
      .amt  (amt),
      .val  (src),
      .c_in (c_in),
      .res  (operand),
      .cout (c_out)
   );

   // R8: a zero register count leaves operand and carry untouched
   always_comb begin
      if (!imm_sel && op_field[REGCNT_B] && rs_val[CNT_W-1:0] == '0) begin
         p_zero_cnt_pass_r8: assert (operand == rm_val && c_out == c_in)
            else $error("zero register count altered the operand");
      end
   end

endmodule

// File: tb/test_opsh_top.sv
module test_opsh_top;

   logic        clk = 1'b0;
   logic        imm_sel;
   logic [11:0] op_field;
   logic [31:0] rm_val;
   logic [31:0] rs_val;
   logic        c_in;
   logic [31:0] operand;
   logic        c_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   opsh_top i_opsh_top (
      .imm_sel  (imm_sel),
      .op_field (op_field),
      .rm_val   (rm_val),
      .rs_val   (rs_val),
      .c_in     (c_in),
      .operand  (operand),
      .c_out    (c_out)
   );

   // bit-serial reference: returns {carry, value}
   function automatic logic [32:0] ref_model(bit isel, logic [11:0] f,
                                             logic [31:0] rm, logic [31:0] rs, bit c);
      logic [31:0] v;
      bit          co;
      int          n;
      int          typ;
      co = c;
      if (isel) begin
         v = {24'd0, f[7:0]};
         n = 2 * int'(f[11:8]);
         for (int i = 0; i < n; i++) begin
            co = v[0];
            v  = {v[0], v[31:1]};
         end
         return {co, v};
      end
      v   = rm;
      typ = int'(f[6:5]);
      if (f[4]) n = int'(rs[7:0]);
      else begin
         n = int'(f[11:7]);
         if (n == 0) begin
            if (typ == 1 || typ == 2) n = 32;
            else if (typ == 3) return {rm[0], c, rm[31:1]};
         end
      end
      for (int i = 0; i < n; i++) begin
         case (typ)
            0: begin co = v[31]; v = {v[30:0], 1'b0}; end
            1: begin co = v[0];  v = {1'b0, v[31:1]}; end
            2: begin co = v[0];  v = {v[31], v[31:1]}; end
            default: begin co = v[0]; v = {v[0], v[31:1]}; end
         endcase
      end
      return {co, v};
   endfunction

   task automatic check(string req, logic [31:0] exp_v, bit exp_c);
      checks++;
      if (operand !== exp_v || c_out !== exp_c) begin
         errors++;
         $display("FAIL %s: operand=%h c_out=%b expected operand=%h c_out=%b (imm_sel=%b field=%h rm=%h rs=%h c=%b)",
                  req, operand, c_out, exp_v, exp_c, imm_sel, op_field, rm_val, rs_val, c_in);
      end
   endtask

   task automatic apply(bit isel, logic [11:0] f, logic [31:0] rm, logic [31:0] rs, bit c);
      @(negedge clk);
      imm_sel  = isel;
      op_field = f;
      rm_val   = rm;
      rs_val   = rs;
      c_in     = c;
      #2;
   endtask

   task automatic run_ref(string req, bit isel, logic [11:0] f,
                          logic [31:0] rm, logic [31:0] rs, bit c);
      logic [32:0] e;
      apply(isel, f, rm, rs, c);
      e = ref_model(isel, f, rm, rs, c);
      check(req, e[31:0], e[32]);
   endtask

   function automatic string tag_for(bit regcnt, int typ, int cnt);
      if (cnt == 0 && regcnt) return "R8";
      if (cnt == 0 && typ == 0) return "R9";
      if (cnt == 0 && typ == 3) return "R7";
      case (typ)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   initial begin
      logic [31:0] pats [4];
      logic [31:0] base_v;
      bit          base_c;
      pats[0] = 32'h0000_0031;
      pats[1] = 32'hA000_0030;
      pats[2] = 32'h8000_0001;
      pats[3] = 32'h5A3C_96E1;

      imm_sel = 1'b0; op_field = '0; rm_val = '0; rs_val = '0; c_in = 1'b0;
      #3;
      check("R9", 32'h0, 1'b0);  // quiet all-zero inputs

      // worked examples
      run_ref("R3", 1'b0, {5'd2, 2'b00, 1'b0, 4'd0}, 32'h30, 32'h0, 1'b0);
      check("R3", 32'h0000_00C0, 1'b0);
      apply(1'b0, {5'd2, 2'b01, 1'b0, 4'd0}, 32'h30, 32'h0, 1'b0);
      check("R4", 32'h0000_000C, 1'b0);
      apply(1'b0, {5'd2, 2'b10, 1'b0, 4'd0}, 32'hA000_0030, 32'h0, 1'b0);
      check("R5", 32'hE800_000C, 1'b0);
      apply(1'b0, {5'd2, 2'b11, 1'b0, 4'd0}, 32'h31, 32'h0, 1'b0);
      check("R6", 32'h4000_000C, 1'b0);
      apply(1'b0, {5'd0, 2'b11, 1'b0, 4'd0}, 32'h31, 32'h0, 1'b1);
      check("R7", 32'h8000_0018, 1'b1);
      apply(1'b0, {4'd0, 1'b0, 2'b00, 1'b1, 4'd0}, 32'h8000_0001, 32'h0000_0021, 1'b1);
      check("R3", 32'h0, 1'b0);
      apply(1'b0, {4'd0, 1'b0, 2'b00, 1'b1, 4'd0}, 32'h8000_0001, 32'h0000_0020, 1'b0);
      check("R3", 32'h0, 1'b1);
      apply(1'b0, {4'd0, 1'b0, 2'b11, 1'b1, 4'd0}, 32'h8000_0001, 32'hFFFF_FF40, 1'b0);
      check("R6", 32'h8000_0001, 1'b1);
      apply(1'b1, 12'h4FF, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
      check("R1", 32'hFF00_0000, 1'b1);

      // register path: every field count and every register count
      for (int typ = 0; typ < 4; typ++) begin
         for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 2; c++) begin
               for (int k = 0; k < 32; k++) begin
                  run_ref(tag_for(1'b0, typ, k), 1'b0,
                          {k[4:0], typ[1:0], 1'b0, k[3:0]}, pats[p], 32'hFFFF_FFFF, c[0]);
               end
               for (int k = 0; k < 256; k++) begin
                  run_ref(tag_for(1'b1, typ, k), 1'b0,
                          {4'hA, 1'b0, typ[1:0], 1'b1, k[3:0]}, pats[p],
                          {k[7:0] ^ 8'h5C, 16'hC3A5, k[7:0]}, c[0]);
               end
            end
         end
      end

      // immediate path: every rotation, register inputs scrambled
      for (int r = 0; r < 16; r++) begin
         for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < 2; c++) begin
               run_ref("R1", 1'b1, {r[3:0], 8'(8'h81 + i * 37)},
                       32'h1357_9BDF ^ i, 32'h0000_0000 + r, c[0]);
            end
         end
      end

      // R2: register index bits must not change the result
      for (int typ = 0; typ < 4; typ++) begin
         for (int k = 1; k < 32; k += 5) begin
            apply(1'b0, {k[4:0], typ[1:0], 1'b0, 4'h0}, 32'h5A3C_96E1, 32'h0, 1'b1);
            base_v = operand;
            base_c = c_out;
            for (int idx = 1; idx < 16; idx++) begin
               apply(1'b0, {k[4:0], typ[1:0], 1'b0, idx[3:0]}, 32'h5A3C_96E1, 32'h0, 1'b1);
               check("R2", base_v, base_c);
            end
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule